// File: doc/BRIEF.md
# Indirect PHY Register Access Sequencer

This block reads and writes 16-bit configuration registers inside a PHY that exposes no memory-mapped access. The only path into the PHY is a pair of words. The block drives a 32-bit control word and reads back a status word that carries an acknowledge flag and 16 bits of read data. Every access is broken into separate steps: capture the address, capture the data, then strobe the write or the read. Each strobe is closed by a four-phase exchange. The strobe stays up until acknowledge is seen high, and the next step starts only after acknowledge is seen low.

A client hands over one request at a time through a ready/valid pair. The request carries a direction, a 16-bit address and, for writes, 16-bit data. The block then runs the whole sequence without further attention. It ends with a one-cycle done pulse, which is paired with an error flag if the PHY stopped answering. Each acknowledge wait samples the flag a limited number of times, with a programmable number of clock cycles between samples. If the expected level never shows up, the access is abandoned, the control word is cleared and the block goes back to idle.

Top module: `phy_indirect_master`

## Requirements
- R1: After reset the control word is zero, the request input is ready, and done and error are low.
- R2: The control word carries the address or data in bits 15:0. The capture-address strobe is bit 16, the capture-data strobe bit 17, the write strobe bit 18 and the read strobe bit 19. At most one strobe is set at a time and all other bits are zero. The acknowledge flag is status bit 16 and the read data is status bits 15:0.
- R3: Every access begins with the same address phase. The control word goes to the address alone, then to the address plus the capture-address strobe. When acknowledge is seen high it goes back to the address alone, and the phase ends when acknowledge is seen low.
- R4: A write continues with data alone, then data plus the capture-data strobe (held until acknowledge high), then data alone (held until acknowledge low). It then drives the write strobe alone until acknowledge is high, then data alone until acknowledge is low, and then drives zero together with the done pulse.
- R5: A read continues with the read strobe alone. When acknowledge is seen high, status bits 15:0 are stored as the read result and the control word goes to zero. When acknowledge is then seen low, done pulses. The read result changes at no other time.
- R6: Within a wait, the acknowledge flag is checked on the first cycle and then every POLL_CYCLES cycles, up to POLL_TRIES checks. A level that first appears at the last check still counts.
- R7: If all POLL_TRIES checks fail, the control word drops to zero, done and error pulse together for one cycle, the read result keeps its old value, and the block is idle again. With the defaults of the bench, a strobe whose acknowledge never comes stays up for 9*POLL_CYCLES+1 cycles.
- R8: A request is taken only while ready is high, and ready is high exactly when no access is in progress. A valid request held while busy starts nothing and alters nothing at the control word.
- R9: Done is a single-cycle pulse, and error is never high without done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Block idle, request may be taken |
| req_write_i | input | 1 | 1 for write, 0 for read |
| req_addr_i | input | FIELD_W | PHY register address |
| req_wdata_i | input | FIELD_W | Write data |
| rsp_done_o | output | 1 | One-cycle end-of-access pulse |
| rsp_err_o | output | 1 | Acknowledge timeout, valid with done |
| rsp_rdata_o | output | FIELD_W | Last successful read result |
| phy_ctl_o | output | CTL_W | Control word toward the PHY |
| phy_stat_i | input | STAT_W | Status word from the PHY |

## Verification
A step register that skips, repeats or stalls shows up on the control word the cycle after the faulty edge: a word out of order, or a strobe that never drops. Both are visible because the bench compares the word against an ordered list of expected words on every clock. A poll counter that is off by one shifts the timeout by POLL_CYCLES cycles, so it shows in the strobe-high cycle count of a stuck access. The same error turns the acknowledge that first arrives at the last check into a false timeout. A read latch that captures at the wrong moment leaves a wrong read result at the done pulse.

// File: rtl/pim_pkg.sv
package pim_pkg;

   typedef enum logic [3:0] {
      S_IDLE,
      S_ADDR,
      S_ADDR_CAP,
      S_ADDR_REL,
      S_DATA,
      S_DATA_CAP,
      S_DATA_REL,
      S_WR,
      S_WR_REL,
      S_RD,
      S_RD_REL
   } step_e;

   typedef enum logic [1:0] {
      W_NONE,
      W_HIGH,
      W_LOW
   } wait_e;

   function automatic wait_e wait_of(step_e s);
      case (s)
         S_ADDR_CAP, S_DATA_CAP, S_WR, S_RD:     return W_HIGH;
         S_ADDR_REL, S_DATA_REL, S_WR_REL, S_RD_REL: return W_LOW;
         default:                                return W_NONE;
      endcase
   endfunction

   function automatic step_e next_of(step_e s, logic is_wr);
      case (s)
         S_ADDR:     return S_ADDR_CAP;
         S_ADDR_CAP: return S_ADDR_REL;
         S_ADDR_REL: return is_wr ? S_DATA : S_RD;
         S_DATA:     return S_DATA_CAP;
         S_DATA_CAP: return S_DATA_REL;
         S_DATA_REL: return S_WR;
         S_WR:       return S_WR_REL;
         S_RD:       return S_RD_REL;
         default:    return S_IDLE;
      endcase
   endfunction

endpackage

// File: rtl/pim_poll_timer.sv
module pim_poll_timer #(
   parameter int POLL_CYCLES = 100,
   parameter int POLL_TRIES  = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart_i,
   input  logic miss_i,
   output logic tick_o,
   output logic last_o
);
   localparam int CNT_W = (POLL_CYCLES > 1) ? $clog2(POLL_CYCLES) : 1;
   localparam int TRY_W = (POLL_TRIES > 1) ? $clog2(POLL_TRIES) : 1;

   logic [TRY_W-1:0] tries_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tries_q <= '0;
      end else if (restart_i) begin
         tries_q <= '0;
      end else if (miss_i) begin
         tries_q <= tries_q + 1'b1;
      end
   end

   assign last_o = (tries_q == TRY_W'(POLL_TRIES - 1));

   generate
      if (POLL_CYCLES == 1) begin : g_every_cycle
         assign tick_o = 1'b1;
      end else begin : g_countdown
         logic [CNT_W-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (restart_i) begin
               cnt_q <= '0;
            end else if (miss_i) begin
               cnt_q <= CNT_W'(POLL_CYCLES - 1);
            end else if (cnt_q != '0) begin
               cnt_q <= cnt_q - 1'b1;
            end
         end
         assign tick_o = (cnt_q == '0);
      end
   endgenerate

endmodule

// File: rtl/pim_ctl_pack.sv
module pim_ctl_pack
   import pim_pkg::*;
#(
   parameter int FIELD_W      = 16,
   parameter int CTL_W        = 32,
   parameter int CAP_ADDR_BIT = 16,
   parameter int CAP_DATA_BIT = 17,
   parameter int WRITE_BIT    = 18,
   parameter int READ_BIT     = 19
) (
   input  step_e              step_i,
   input  logic [FIELD_W-1:0] addr_i,
   input  logic [FIELD_W-1:0] data_i,
   output logic [CTL_W-1:0]   ctl_o
);
   localparam logic [CTL_W-1:0] STB_CA = CTL_W'(1) << CAP_ADDR_BIT;
   localparam logic [CTL_W-1:0] STB_CD = CTL_W'(1) << CAP_DATA_BIT;
   localparam logic [CTL_W-1:0] STB_WR = CTL_W'(1) << WRITE_BIT;
   localparam logic [CTL_W-1:0] STB_RD = CTL_W'(1) << READ_BIT;

   logic [CTL_W-1:0] a_word;
   logic [CTL_W-1:0] d_word;

   assign a_word = CTL_W'(addr_i);
   assign d_word = CTL_W'(data_i);

   always_comb begin
      case (step_i)
         S_ADDR, S_ADDR_REL:             ctl_o = a_word;
         S_ADDR_CAP:                     ctl_o = a_word | STB_CA;
         S_DATA, S_DATA_REL, S_WR_REL:   ctl_o = d_word;
         S_DATA_CAP:                     ctl_o = d_word | STB_CD;
         S_WR:                           ctl_o = STB_WR;
         S_RD:                           ctl_o = STB_RD;
         default:                        ctl_o = '0;
      endcase
   end

endmodule

// File: rtl/pim_step_fsm.sv
module pim_step_fsm
   import pim_pkg::*;
#(
   parameter int FIELD_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid_i,
   input  logic               req_write_i,
   input  logic [FIELD_W-1:0] req_addr_i,
   input  logic [FIELD_W-1:0] req_wdata_i,
   output logic               req_ready_o,
   input  logic               ack_i,
   input  logic [FIELD_W-1:0] stat_data_i,
   input  logic               tick_i,
   input  logic               last_i,
   output logic               restart_o,
   output logic               miss_o,
   output step_e              step_o,
   output logic [FIELD_W-1:0] addr_o,
   output logic [FIELD_W-1:0] data_o,
   output logic               done_o,
   output logic               err_o,
   output logic [FIELD_W-1:0] rdata_o
);
   step_e              step_q;
   logic               is_wr_q;
   logic [FIELD_W-1:0] addr_q;
   logic [FIELD_W-1:0] data_q;
   logic [FIELD_W-1:0] rdata_q;
   logic               done_q;
   logic               err_q;

   wait_e wt;
   logic  hit;
   logic  accept;
   logic  advance;
   logic  give_up;
   step_e nxt;

   always_comb begin
      wt      = wait_of(step_q);
      nxt     = next_of(step_q, is_wr_q);
      hit     = (wt == W_HIGH && ack_i) || (wt == W_LOW && !ack_i);
      accept  = req_valid_i && (step_q == S_IDLE);
      advance = (step_q != S_IDLE) &&
                ((wt == W_NONE) || (tick_i && hit));
      miss_o  = (wt != W_NONE) && tick_i && !hit;
      give_up = miss_o && last_i;
   end

   assign restart_o = accept || advance || give_up;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step_q  <= S_IDLE;
         is_wr_q <= 1'b0;
         addr_q  <= '0;
         data_q  <= '0;
         rdata_q <= '0;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         err_q  <= 1'b0;
         if (accept) begin
            step_q  <= S_ADDR;
            is_wr_q <= req_write_i;
            addr_q  <= req_addr_i;
            data_q  <= req_wdata_i;
         end else if (advance) begin
            step_q <= nxt;
            if (step_q == S_RD) begin
               rdata_q <= stat_data_i;
            end
            if (nxt == S_IDLE) begin
               done_q <= 1'b1;
            end
         end else if (give_up) begin
            step_q <= S_IDLE;
            done_q <= 1'b1;
            err_q  <= 1'b1;
         end
      end
   end

   assign req_ready_o = (step_q == S_IDLE);
   assign step_o      = step_q;
   assign addr_o      = addr_q;
   assign data_o      = data_q;
   assign done_o      = done_q;
   assign err_o       = err_q;
   assign rdata_o     = rdata_q;

endmodule

// File: rtl/phy_indirect_master.sv
module phy_indirect_master
   import pim_pkg::*;
#(
   parameter int FIELD_W      = 16,
   parameter int CTL_W        = 32,
   parameter int STAT_W       = 32,
   parameter int CAP_ADDR_BIT = 16,
   parameter int CAP_DATA_BIT = 17,
   parameter int WRITE_BIT    = 18,
   parameter int READ_BIT     = 19,
   parameter int ACK_BIT      = 16,
   parameter int POLL_CYCLES  = 100,
   parameter int POLL_TRIES   = 10
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid_i,
   output logic               req_ready_o,
   input  logic               req_write_i,
   input  logic [FIELD_W-1:0] req_addr_i,
   input  logic [FIELD_W-1:0] req_wdata_i,
   output logic               rsp_done_o,
   output logic               rsp_err_o,
   output logic [FIELD_W-1:0] rsp_rdata_o,
   output logic [CTL_W-1:0]   phy_ctl_o,
   input  logic [STAT_W-1:0]  phy_stat_i
);
   generate
      if (CAP_ADDR_BIT < FIELD_W || CAP_DATA_BIT < FIELD_W ||
          WRITE_BIT < FIELD_W || READ_BIT < FIELD_W) begin : g_bad_field
         $error("strobe bits overlap the address/data field");
      end
      if (CAP_ADDR_BIT >= CTL_W || CAP_DATA_BIT >= CTL_W ||
          WRITE_BIT >= CTL_W || READ_BIT >= CTL_W) begin : g_bad_ctl
         $error("strobe bit beyond control word");
      end
      if (CAP_ADDR_BIT == CAP_DATA_BIT || CAP_ADDR_BIT == WRITE_BIT ||
          CAP_ADDR_BIT == READ_BIT || CAP_DATA_BIT == WRITE_BIT ||
          CAP_DATA_BIT == READ_BIT || WRITE_BIT == READ_BIT) begin : g_bad_dup
         $error("strobe bits must be distinct");
      end
      if (ACK_BIT < FIELD_W || ACK_BIT >= STAT_W) begin : g_bad_ack
         $error("acknowledge bit misplaced in status word");
      end
      if (POLL_CYCLES < 1 || POLL_TRIES < 1) begin : g_bad_poll
         $error("poll interval and tries must be at least one");
      end
   endgenerate

   step_e              step;
   logic [FIELD_W-1:0] addr_r;
   logic [FIELD_W-1:0] data_r;
   logic               tick;
   logic               last;
   logic               restart;
   logic               miss;

   pim_step_fsm #(
      .FIELD_W (FIELD_W)
   ) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid_i (req_valid_i),
      .req_write_i (req_write_i),
      .req_addr_i  (req_addr_i),
      .req_wdata_i (req_wdata_i),
      .req_ready_o (req_ready_o),
      .ack_i       (phy_stat_i[ACK_BIT]),
      .stat_data_i (phy_stat_i[FIELD_W-1:0]),
      .tick_i      (tick),
      .last_i      (last),
      .restart_o   (restart),
      .miss_o      (miss),
      .step_o      (step),
      .addr_o      (addr_r),
      .data_o      (data_r),
      .done_o      (rsp_done_o),
      .err_o       (rsp_err_o),
      .rdata_o     (rsp_rdata_o)
   );

   pim_poll_timer #(
      .POLL_CYCLES (POLL_CYCLES),
      .POLL_TRIES  (POLL_TRIES)
   ) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart_i (restart),
      .miss_i    (miss),
      .tick_o    (tick),
      .last_o    (last)
   );

   pim_ctl_pack #(
      .FIELD_W      (FIELD_W),
      .CTL_W        (CTL_W),
      .CAP_ADDR_BIT (CAP_ADDR_BIT),
      .CAP_DATA_BIT (CAP_DATA_BIT),
      .WRITE_BIT    (WRITE_BIT),
      .READ_BIT     (READ_BIT)
   ) u_pack (
      .step_i (step),
      .addr_i (addr_r),
      .data_i (data_r),
      .ctl_o  (phy_ctl_o)
   );

endmodule

// File: rtl/pim_checker.sv
module pim_checker #(
   parameter int FIELD_W      = 16,
   parameter int CTL_W        = 32,
   parameter int STAT_W       = 32,
   parameter int CAP_ADDR_BIT = 16,
   parameter int CAP_DATA_BIT = 17,
   parameter int WRITE_BIT    = 18,
   parameter int READ_BIT     = 19,
   parameter int ACK_BIT      = 16
) (
   input logic               clk,
   input logic               rst_n,
   input logic               req_valid_i,
   input logic               req_ready_o,
   input logic               rsp_done_o,
   input logic               rsp_err_o,
   input logic [FIELD_W-1:0] rsp_rdata_o,
   input logic [CTL_W-1:0]   phy_ctl_o,
   input logic [STAT_W-1:0]  phy_stat_i
);
   localparam logic [CTL_W-1:0] LEGAL =
      ((CTL_W'(1) << FIELD_W) - 1) |
      (CTL_W'(1) << CAP_ADDR_BIT) | (CTL_W'(1) << CAP_DATA_BIT) |
      (CTL_W'(1) << WRITE_BIT) | (CTL_W'(1) << READ_BIT);

   logic ack;
   assign ack = phy_stat_i[ACK_BIT];

   // R2
   assert_legal_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ((phy_ctl_o & ~LEGAL) == '0) &&
      $onehot0({phy_ctl_o[CAP_ADDR_BIT], phy_ctl_o[CAP_DATA_BIT],
                phy_ctl_o[WRITE_BIT], phy_ctl_o[READ_BIT]}));

   assert_capaddr_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(phy_ctl_o[CAP_ADDR_BIT]) && !rsp_err_o) |-> $past(ack));

   assert_wrstb_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(phy_ctl_o[WRITE_BIT]) && !rsp_err_o) |-> $past(ack));

   assert_rdata_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rsp_rdata_o) |-> $past(phy_ctl_o[READ_BIT] && ack));

   assert_timeout_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err_o |-> (phy_ctl_o == '0) && req_ready_o);

   assert_done_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done_o |-> req_ready_o);

   assert_accept_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid_i && req_ready_o) |=> !req_ready_o);

   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done_o |=> !rsp_done_o);

   assert_err_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err_o |-> rsp_done_o);

endmodule

bind phy_indirect_master pim_checker #(
   .FIELD_W      (FIELD_W),
   .CTL_W        (CTL_W),
   .STAT_W       (STAT_W),
   .CAP_ADDR_BIT (CAP_ADDR_BIT),
   .CAP_DATA_BIT (CAP_DATA_BIT),
   .WRITE_BIT    (WRITE_BIT),
   .READ_BIT     (READ_BIT),
   .ACK_BIT      (ACK_BIT)
) u_pim_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_valid_i (req_valid_i),
   .req_ready_o (req_ready_o),
   .rsp_done_o  (rsp_done_o),
   .rsp_err_o   (rsp_err_o),
   .rsp_rdata_o (rsp_rdata_o),
   .phy_ctl_o   (phy_ctl_o),
   .phy_stat_i  (phy_stat_i)
);

// File: tb/phy_indirect_master_bench.sv
`timescale 1ns/1ps
module phy_indirect_master_bench;
   localparam int POLL = 4;
   localparam int TRIES = 10;
   localparam logic [31:0] CA = 32'h0001_0000;
   localparam logic [31:0] CD = 32'h0002_0000;
   localparam logic [31:0] WS = 32'h0004_0000;
   localparam logic [31:0] RS = 32'h0008_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_write = 1'b0;
   logic [15:0] req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic        done;
   logic        err;
   logic [15:0] rdata;
   logic [31:0] ctl;
   logic [31:0] stat;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   phy_indirect_master #(
      .POLL_CYCLES (POLL),
      .POLL_TRIES  (TRIES)
   ) u_phy_indirect_master (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid_i (req_valid),
      .req_ready_o (req_ready),
      .req_write_i (req_write),
      .req_addr_i  (req_addr),
      .req_wdata_i (req_wdata),
      .rsp_done_o  (done),
      .rsp_err_o   (err),
      .rsp_rdata_o (rdata),
      .phy_ctl_o   (ctl),
      .phy_stat_i  (stat)
   );

   // PHY-side responder: ack follows "any strobe set" after lat cycles
   int          lat = 1;
   int          mode = 0;   // 0 normal, 1 ack stuck low, 2 ack stuck high
   int          rcnt;
   logic        ack_q;
   logic [15:0] cap_a;
   logic [15:0] cap_d;
   logic [15:0] regs [16];
   logic        want;

   assign want = |ctl[19:16];
   assign stat = {15'b0, ack_q, (ctl[19] ? regs[cap_a[3:0]] : 16'hDEAD)};

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack_q <= 1'b0;
         rcnt  <= 0;
         cap_a <= '0;
         cap_d <= '0;
         for (int i = 0; i < 16; i++) regs[i] <= 16'h5A00 | 16'(i);
      end else begin
         if (ctl[16]) cap_a <= ctl[15:0];
         if (ctl[17]) cap_d <= ctl[15:0];
         if (ctl[18]) regs[cap_a[3:0]] <= cap_d;
         if (mode == 1) begin
            ack_q <= 1'b0;
            rcnt  <= 0;
         end else if (mode == 2) begin
            ack_q <= 1'b1;
            rcnt  <= 0;
         end else if (want != ack_q) begin
            if (rcnt >= lat - 1) begin
               ack_q <= want;
               rcnt  <= 0;
            end else begin
               rcnt <= rcnt + 1;
            end
         end else begin
            rcnt <= 0;
         end
      end
   end

   // bench-side reference
   logic [15:0] shadow [16];
   logic [15:0] last_rd = '0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // fail_at: 0 none, 1 at address-capture wait, 2 at address-release wait
   task automatic run_op(input bit wr, input logic [15:0] a, input logic [15:0] d,
                         input int fail_at, input bit hold_valid,
                         output int stb_cycles);
      logic [31:0] q[$];
      logic [31:0] A, D;
      bit seen_done;
      A = {16'h0, a};
      D = {16'h0, d};
      stb_cycles = 0;
      q.push_back(A);
      q.push_back(A | CA);
      if (fail_at == 1) begin
         q.push_back(32'h0);
      end else if (fail_at == 2) begin
         q.push_back(A);
         q.push_back(32'h0);
      end else if (wr) begin
         q.push_back(A); q.push_back(D); q.push_back(D | CD); q.push_back(D);
         q.push_back(WS); q.push_back(D); q.push_back(32'h0);
      end else begin
         q.push_back(A); q.push_back(RS); q.push_back(32'h0);
      end
      @(negedge clk);
      chk(req_ready == 1'b1, "R8", "ready before request", 32'(req_ready), 32'h1);
      req_valid = 1'b1;
      req_write = wr;
      req_addr  = a;
      req_wdata = d;
      @(negedge clk);
      if (hold_valid) begin
         req_write = ~wr;
         req_addr  = 16'h00FF;
         req_wdata = 16'h1234;
      end else begin
         req_valid = 1'b0;
      end
      seen_done = 1'b0;
      for (int n = 0; n < 3000 && !seen_done; n++) begin
         if (ctl[19:16] != 4'h0) stb_cycles++;
         if (ctl == q[0]) begin
            checks++;
         end else if (q.size() > 1 && ctl == q[1]) begin
            void'(q.pop_front());
            checks++;
         end else begin
            chk(1'b0, wr ? "R4" : "R5", "control word order", ctl, q[0]);
         end
         if (done) begin
            seen_done = 1'b1;
            if (hold_valid) req_valid = 1'b0;
            chk(q.size() == 1, (fail_at != 0) ? "R7" : (wr ? "R4" : "R5"),
                "all steps seen", 32'(q.size()), 32'h1);
            chk(err == (fail_at != 0), "R7", "error flag", 32'(err), 32'(fail_at != 0));
            chk(ctl == 32'h0, "R7", "word zero at done", ctl, 32'h0);
            chk(req_ready == 1'b1, "R8", "ready at done", 32'(req_ready), 32'h1);
            if (!wr && fail_at == 0) last_rd = shadow[a[3:0]];
            if (wr && fail_at == 0) shadow[a[3:0]] = d;
            chk(rdata == last_rd, wr ? "R7" : "R5", "read result", 32'(rdata), 32'(last_rd));
         end else begin
            chk(req_ready == 1'b0, "R8", "busy ready", 32'(req_ready), 32'h0);
            chk(err == 1'b0, "R9", "error without done", 32'(err), 32'h0);
         end
         @(negedge clk);
      end
      chk(seen_done, "R9", "done seen", 32'(seen_done), 32'h1);
      chk(done == 1'b0, "R9", "done one cycle", 32'(done), 32'h0);
      for (int k = 0; k < 3; k++) begin
         chk(ctl == 32'h0 && req_ready, "R8", "idle after access", ctl, 32'h0);
         @(negedge clk);
      end
   endtask

   initial begin
      #(10 * 150000);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int sc;
      for (int i = 0; i < 16; i++) shadow[i] = 16'h5A00 | 16'(i);
      repeat (3) @(negedge clk);
      // R1 reset values
      chk(ctl == 32'h0, "R1", "reset word", ctl, 32'h0);
      chk(req_ready == 1'b1, "R1", "reset ready", 32'(req_ready), 32'h1);
      chk(done == 1'b0 && err == 1'b0, "R1", "reset done/err", {done, err}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(ctl == 32'h0 && req_ready, "R1", "after release", ctl, 32'h0);

      // R2 R3 R4 write, fast PHY
      lat = 1;
      run_op(1'b1, 16'h0003, 16'hBEEF, 0, 1'b0, sc);
      // R5 read back written value
      lat = 2;
      run_op(1'b0, 16'h0003, 16'h0000, 0, 1'b0, sc);
      // R5 read of an untouched register
      lat = 1;
      run_op(1'b0, 16'h0007, 16'h0000, 0, 1'b0, sc);
      // R6 ack appearing exactly at the last check succeeds
      lat = (TRIES - 1) * POLL;
      run_op(1'b1, 16'h1005, 16'h0028, 0, 1'b0, sc);
      lat = 3;
      run_op(1'b0, 16'h1005, 16'h0000, 0, 1'b0, sc);
      // R7 ack one cycle too late times out at the address capture
      lat = (TRIES - 1) * POLL + 1;
      run_op(1'b0, 16'h0009, 16'h0000, 1, 1'b0, sc);
      chk(sc == (TRIES - 1) * POLL + 1, "R6", "strobe cycles late ack", sc,
          (TRIES - 1) * POLL + 1);
      // R7 ack stuck low
      lat = 1;
      mode = 1;
      run_op(1'b1, 16'h000A, 16'h7777, 1, 1'b0, sc);
      chk(sc == (TRIES - 1) * POLL + 1, "R7", "strobe cycles stuck low", sc,
          (TRIES - 1) * POLL + 1);
      // R7 ack stuck high: timeout in address release
      mode = 2;
      repeat (2) @(negedge clk);
      run_op(1'b0, 16'h000B, 16'h0000, 2, 1'b0, sc);
      chk(sc == 1, "R7", "capture strobe cycles stuck high", sc, 1);
      mode = 0;
      repeat (4) @(negedge clk);
      // R8 valid held while busy starts nothing else
      lat = 2;
      run_op(1'b0, 16'h0003, 16'h0000, 0, 1'b1, sc);
      run_op(1'b1, 16'h000C, 16'h00C3, 0, 1'b0, sc);
      run_op(1'b0, 16'h000C, 16'h0000, 0, 1'b0, sc);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule